// File: doc/BRIEF.md
# Binary Erasure Peeling Decoder

This block recovers erased bits of a six-bit codeword from a fixed (6,3) sparse parity-check code. A caller presents the received word together with one erasure flag per bit and pulses `start`. The decoder then visits the three parity checks in a fixed rotation, one check per clock. Whenever a check sees exactly one erased bit among its members, it fills that bit with the XOR of the known members and clears its flag. A recovered bit is an ordinary known bit for every later check, so erasures that were blocked can be solved on later passes.

Decoding stops in two cases: no erasures remain, or a full pass over all three checks recovers nothing. The block then computes the three-bit syndrome of the resolved word. It reports the word, any flags that are still set, the three message bits and a fail indication, and marks the result with a one-cycle `done` pulse. The code is systematic, so the message is read straight from the front of the word.

Top module: `bec_peel_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, and at the first sample after it, `done` and `fail` are 0 and `word_out`, `erase_out` and `msg_out` are all zero.
- R2: Bit i of `word_in`, `erase_in`, `word_out` and `erase_out` is codeword position i, with position 0 the leftmost. Check A covers positions {0,1,2,3}. Check B covers {2,3,5}. Check C covers {0,3,4}. A position flagged in `erase_in` ignores its `word_in` value.
- R3: A check may fill an erased position only when that position is the sole flagged member of the check. The filled value makes the XOR of all the check's members zero, and the position's flag is then cleared. Known positions never change.
- R4: Recovered positions serve as known inputs to later checks. The received word ?01?11 (`word_in` don't-care at flags, `erase_in`=6'b001001) resolves to 101011 (`word_out`=6'b110101).
- R5: An accepted start loads the word at that edge. Each following clock either evaluates one check, in the order A, B, C, A, …, or detects that no flags remain and ends. The clock after the end sets `done`.
- R6: If a full A-B-C pass recovers nothing while flags remain, decoding ends with `fail`=1. The unresolved positions stay set in `erase_out` and read as 0 in `word_out`.
- R7: `fail` is also 1 when the syndrome of the resolved word (with unresolved positions taken as 0) is nonzero. This covers a non-erased bit that was received wrong. Otherwise `fail` is 0.
- R8: `msg_out[i]` equals resolved codeword position i for i = 0, 1, 2.
- R9: `start` has no effect while a decode is in progress.
- R10: `done` is high for exactly one cycle. `word_out`, `erase_out`, `msg_out` and `fail` change only together with that pulse and hold until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin decoding the presented word (honoured only when idle) |
| word_in | input | 6 | Received bits, position i on bit i |
| erase_in | input | 6 | Erasure flags, position i on bit i |
| done | output | 1 | One-cycle result strobe |
| fail | output | 1 | Stalled with erasures left, or nonzero syndrome |
| word_out | output | 6 | Resolved codeword |
| erase_out | output | 6 | Flags still unresolved at the end |
| msg_out | output | 3 | Message bits, positions 0..2 |

## Verification
The hardest cases to reach from the ports are the multi-pass ones. In these, one check can only fire after a check later in the rotation has filled a shared position, so the decode has to wrap round the schedule before it converges or stalls. The stimulus reaches them by sweeping all 64 erasure patterns over each of the eight valid codewords, with the bits under the flags inverted. A behavioural model predicts the cycle of `done` and the result for every run. Extra runs flip a non-erased bit to force the syndrome path, and pulse `start` in the middle of a decode.

// File: rtl/bec_pkg.sv
// Package: shared sizes, types and the fixed check structure of the (6,3) code.
// Assumes position i of a word is carried on vector bit i.
package bec_pkg;
    localparam int N_BITS   = 6;
    localparam int N_CHECKS = 3;
    localparam int K_BITS   = 3;
    localparam int IDX_W    = $clog2(N_CHECKS);

    typedef logic [N_BITS-1:0]   word_t;
    typedef logic [N_CHECKS-1:0] syn_t;
    typedef logic [IDX_W-1:0]    idx_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } state_t;

    // Member positions of each check, as a mask over the word.
    function automatic word_t check_mask(input int c);
        case (c)
            0:       check_mask = 6'b001111; // positions 0,1,2,3
            1:       check_mask = 6'b101100; // positions 2,3,5
            default: check_mask = 6'b011001; // positions 0,3,4
        endcase
    endfunction
endpackage

// File: rtl/bec_check_eval.sv
// Evaluates one parity check against the current word and flags.
// Reports whether exactly one member is erased, which one (one-hot) and
// the value that restores even parity. Assumes erased bits hold 0.
module bec_check_eval
    import bec_pkg::*;
#(
    parameter word_t MASK = '0
) (
    input  word_t word_i,
    input  word_t erase_i,
    output logic  solvable_o,
    output word_t fix_onehot_o,
    output logic  fix_val_o
);
    word_t unknown;

    // Locate erased members and decide solvability.
    always_comb begin
        unknown      = erase_i & MASK;
        solvable_o   = (unknown != '0) && ((unknown & (unknown - 1'b1)) == '0);
        fix_onehot_o = solvable_o ? unknown : '0;
        fix_val_o    = ^(word_i & MASK & ~erase_i);
    end
endmodule

// File: rtl/bec_syndrome.sv
// Computes the syndrome of a word over all checks, one bit per check.
module bec_syndrome
    import bec_pkg::*;
(
    input  word_t word_i,
    output syn_t  syn_o
);
    for (genvar c = 0; c < N_CHECKS; c++) begin : g_syn
        assign syn_o[c] = ^(word_i & check_mask(c));
    end
endmodule

// File: rtl/bec_peel_ctrl.sv
// Sequencer for peeling: loads a word on an idle start, visits one check per
// clock in rotation, applies a single fix when the selected check is solvable,
// and ends when flags are gone or a full pass made no progress.
// Assumes the fix inputs are derived combinationally from word_q/erase_q.
module bec_peel_ctrl
    import bec_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  word_t word_in,
    input  word_t erase_in,
    input  logic  sel_solvable,
    input  word_t sel_onehot,
    input  logic  sel_val,
    output idx_t  chk_idx,
    output word_t word_q,
    output word_t erase_q,
    output logic  finish
);
    localparam idx_t LAST_IDX = idx_t'(N_CHECKS - 1);

    state_t state;
    logic   progress;

    assign finish = (state == ST_FINISH);

    // State, schedule and working word registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            chk_idx  <= '0;
            progress <= 1'b0;
            word_q   <= '0;
            erase_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        word_q   <= word_in & ~erase_in;
                        erase_q  <= erase_in;
                        chk_idx  <= '0;
                        progress <= 1'b0;
                        state    <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (erase_q == '0) begin
                        state <= ST_FINISH;
                    end else begin
                        if (sel_solvable) begin
                            word_q  <= (word_q & ~sel_onehot) | (sel_val ? sel_onehot : '0);
                            erase_q <= erase_q & ~sel_onehot;
                        end
                        if (chk_idx == LAST_IDX) begin
                            if (progress || sel_solvable) begin
                                chk_idx  <= '0;
                                progress <= 1'b0;
                            end else begin
                                state <= ST_FINISH;
                            end
                        end else begin
                            chk_idx  <= chk_idx + 1'b1;
                            progress <= progress | sel_solvable;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // R3: flags only ever clear while decoding.
    p_flags_only_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) && ($past(state) != ST_IDLE) |-> ((erase_q & ~$past(erase_q)) == '0));

    // R3: known positions keep their value while decoding.
    p_known_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) && ($past(state) != ST_IDLE) |->
            (((word_q ^ $past(word_q)) & ~$past(erase_q)) == '0));

    // R5: at most one position is recovered per clock.
    p_one_fix_per_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) && ($past(state) != ST_IDLE) |->
            ($countones($past(erase_q) & ~erase_q) <= 1));

    // R9: a start during a decode does not reload the word.
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) && start |=> ((erase_q & ~$past(erase_q)) == '0));

    // R5: the schedule index never leaves the check range.
    p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chk_idx <= LAST_IDX);
endmodule

// File: rtl/bec_peel_decoder.sv
// Top: erasure peeling decoder for the fixed (6,3) code. Builds one check
// evaluator per check, muxes the scheduled one into the sequencer, and
// registers the result with the syndrome verdict on a one-cycle done strobe.
// Assumes start is synchronous to clk.
module bec_peel_decoder
    import bec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [N_BITS-1:0]   word_in,
    input  logic [N_BITS-1:0]   erase_in,
    output logic                done,
    output logic                fail,
    output logic [N_BITS-1:0]   word_out,
    output logic [N_BITS-1:0]   erase_out,
    output logic [K_BITS-1:0]   msg_out
);
    idx_t  chk_idx;
    word_t word_q;
    word_t erase_q;
    logic  finish;
    syn_t  syn;

    logic  solv_arr [N_CHECKS];
    word_t oh_arr   [N_CHECKS];
    logic  val_arr  [N_CHECKS];

    logic  sel_solvable;
    word_t sel_onehot;
    logic  sel_val;

    for (genvar c = 0; c < N_CHECKS; c++) begin : g_chk
        bec_check_eval #(.MASK(check_mask(c))) u_eval (
            .word_i       (word_q),
            .erase_i      (erase_q),
            .solvable_o   (solv_arr[c]),
            .fix_onehot_o (oh_arr[c]),
            .fix_val_o    (val_arr[c])
        );
    end

    // Pick the evaluator of the currently scheduled check.
    always_comb begin
        sel_solvable = 1'b0;
        sel_onehot   = '0;
        sel_val      = 1'b0;
        for (int c = 0; c < N_CHECKS; c++) begin
            if (chk_idx == idx_t'(c)) begin
                sel_solvable = solv_arr[c];
                sel_onehot   = oh_arr[c];
                sel_val      = val_arr[c];
            end
        end
    end

    bec_peel_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .word_in      (word_in),
        .erase_in     (erase_in),
        .sel_solvable (sel_solvable),
        .sel_onehot   (sel_onehot),
        .sel_val      (sel_val),
        .chk_idx      (chk_idx),
        .word_q       (word_q),
        .erase_q      (erase_q),
        .finish       (finish)
    );

    bec_syndrome u_syn (
        .word_i (word_q),
        .syn_o  (syn)
    );

    // Result registers, loaded only with the done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            fail      <= 1'b0;
            word_out  <= '0;
            erase_out <= '0;
            msg_out   <= '0;
        end else if (finish) begin
            done      <= 1'b1;
            fail      <= (erase_q != '0) || (syn != '0);
            word_out  <= word_q;
            erase_out <= erase_q;
            msg_out   <= word_q[K_BITS-1:0];
        end else begin
            done <= 1'b0;
        end
    end

    // R10: done lasts a single cycle.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: results hold between strobes.
    p_out_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(word_out) && $stable(erase_out) && $stable(msg_out) && $stable(fail)));

    // R6: leftover flags always come with fail.
    p_stall_fails_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && (erase_out != '0) |-> fail);

    // R6: unresolved positions read as zero.
    p_unresolved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((word_out & erase_out) == '0));

    // R8: message mirrors the first codeword positions.
    p_msg_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_out == word_out[K_BITS-1:0]);
endmodule

// File: tb/sim_bec_peel_decoder.sv
module sim_bec_peel_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [5:0] word_in = '0;
    logic [5:0] erase_in = '0;
    logic       done, fail;
    logic [5:0] word_out, erase_out;
    logic [2:0] msg_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // Codewords with bit i = position i (strings reversed).
    logic [5:0] cw [8] = '{6'b000000, 6'b100110, 6'b010011, 6'b110101,
                           6'b001111, 6'b101001, 6'b011100, 6'b111010};

    bec_peel_decoder u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .word_in(word_in),
        .erase_in(erase_in), .done(done), .fail(fail), .word_out(word_out),
        .erase_out(erase_out), .msg_out(msg_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles exp < %0d", cycles, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h exp %0h", req, what, got, exp);
        end
    endtask

    // Membership test of position p in check c.
    function automatic bit member(input int c, input int p);
        case (c)
            0: return (p <= 3);
            1: return (p == 2 || p == 3 || p == 5);
            default: return (p == 0 || p == 3 || p == 4);
        endcase
    endfunction

    // Behavioural reference: cycles in decode, resolved word, flags, fail.
    task automatic model(input logic [5:0] w_in, input logic [5:0] e_in,
                         output int lat, output logic [5:0] w, output logic [5:0] e,
                         output bit f);
        int  idx = 0;
        bit  prog = 0;
        w = w_in & ~e_in;
        e = e_in;
        lat = 0;
        forever begin
            int  nunk = 0;
            int  pos  = -1;
            bit  par  = 0;
            bit  solved = 0;
            lat++;
            if (e == 0) break;
            for (int p = 0; p < 6; p++) begin
                if (member(idx, p)) begin
                    if (e[p]) begin nunk++; pos = p; end
                    else par ^= w[p];
                end
            end
            if (nunk == 1) begin
                w[pos] = par; e[pos] = 1'b0; solved = 1;
            end
            if (idx == 2) begin
                if (!(prog || solved)) break;
                idx = 0; prog = 0;
            end else begin
                idx++; prog = prog || solved;
            end
        end
        f = (e != 0);
        for (int c = 0; c < 3; c++) begin
            bit s = 0;
            for (int p = 0; p < 6; p++) if (member(c, p)) s ^= w[p];
            if (s) f = 1;
        end
    endtask

    // One decode; optional start pulse mid-run with a different word (R9).
    task automatic run_case(input logic [5:0] w_in, input logic [5:0] e_in,
                            input bit poke, input string tag);
        int lat; logic [5:0] ew, ee; bit ef;
        model(w_in, e_in, lat, ew, ee, ef);
        @(negedge clk);
        word_in = w_in; erase_in = e_in; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= lat + 1; k++) begin
            @(negedge clk);
            if (poke && k == 1) begin
                word_in = ~w_in; erase_in = 6'b000000; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            chk("R5", {tag, " done timing"}, done, (k == lat + 1));
            if (k == lat + 1) begin
                chk("R3", {tag, " word_out"}, word_out, ew);
                chk("R6", {tag, " erase_out"}, erase_out, ee);
                chk("R7", {tag, " fail"}, fail, ef);
                chk("R8", {tag, " msg_out"}, msg_out, ew[2:0]);
            end
        end
        start = 1'b0;
        @(negedge clk);
        chk("R10", {tag, " done low after pulse"}, done, 0);
        chk("R10", {tag, " word_out held"}, word_out, ew);
        chk("R10", {tag, " fail held"}, fail, ef);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done after reset", done, 0);
        chk("R1", "fail after reset", fail, 0);
        chk("R1", "word_out after reset", word_out, 0);
        chk("R1", "erase_out after reset", erase_out, 0);
        chk("R1", "msg_out after reset", msg_out, 0);

        // R4: worked example ?01?11, garbage under flags; R2 mapping.
        run_case(6'b111101, 6'b001001, 0, "R4 example");
        chk("R4", "example word", word_out, 6'b110101);
        chk("R8", "example msg", msg_out, 3'b101);
        chk("R7", "example fail", fail, 0);

        // R6: stall with flags on positions 0..3.
        run_case(6'b110101, 6'b001111, 0, "R6 stall");
        chk("R6", "stall fail", fail, 1);
        chk("R6", "stall flags kept", erase_out, 6'b001111);

        // R7: non-erased bit wrong, no erasures.
        run_case(6'b100101, 6'b000000, 0, "R7 biterr");
        chk("R7", "bit error fail", fail, 1);

        // R9: start while busy is ignored.
        run_case(6'b111101, 6'b001001, 1, "R9 busy start");
        chk("R9", "busy start word", word_out, 6'b110101);

        // R2/R3/R4/R5: sweep every erasure pattern on every codeword.
        for (int i = 0; i < 8; i++) begin
            for (int e = 0; e < 64; e++) begin
                run_case(cw[i] ^ 6'(e), 6'(e), 0, "R2 sweep");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule